// File: doc/BRIEF.md
# Fetch Address Sequencer with Return Stack

This block produces the instruction-fetch address for a small microcontroller core. It keeps a 13-bit program counter, which covers an 8K-word logical code space, and an eight-entry hardware stack of return addresses. Only the lowest 2K words of program memory are built, so the fetch address is the low 11 bits of the counter. Any counter value above 07FFh therefore folds back into the physical range.

The instruction decoder drives a set of commands: step forward, jump to a target, call a target, and return. The interrupt controller drives a single strobe when an interrupt is accepted. A call saves the address after the current one and then loads the target. An accepted interrupt saves the current counter value and then loads the fixed vector 0004h. Any kind of return takes the newest saved address off the stack and loads it into the counter. Reset sends the counter to 0000h.

The stack is a ring with no overflow or underflow indication. When a ninth entry is saved it overwrites the oldest one. A return from an empty stack loads whatever entry the wrapped pointer selects.

Top module: `pc_stack_unit`

## Requirements
- R1: While reset is low, the counter goes to 0000h, the stack pointer goes to zero and every stack entry is cleared. A return issued straight after reset therefore loads 0000h.
- R2: When no command and no interrupt strobe is asserted, the counter keeps its value.
- R3: The increment command adds one to the counter modulo 2^13, so 1FFFh is followed by 0000h.
- R4: The fetch address is always bits 10:0 of the counter. For example, a counter value of 0ABCh fetches from 2BCh.
- R5: The jump command loads the 13-bit target into the counter and leaves the stack alone.
- R6: The call command pushes the counter value plus one (13 bits, modulo 2^13) and loads the target.
- R7: The return command pops the newest stack entry into the counter, in last-in first-out order.
- R8: The interrupt strobe pushes the current counter value and loads 0004h.
- R9: When several inputs are asserted in the same cycle, only one of them acts. The order of precedence, highest first, is: interrupt strobe, return, call, jump, increment. The losing commands neither move the counter nor touch the stack.
- R10: The stack holds eight entries in a ring. After nine pushes of values a1 to a9, nine pops return a9, a8, a7, a6, a5, a4, a3, a2 and then a9 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_take | input | 1 | Interrupt accepted strobe |
| cmd_inc | input | 1 | Step the counter by one |
| cmd_jump | input | 1 | Load the target |
| cmd_call | input | 1 | Push the return address and load the target |
| cmd_ret | input | 1 | Pop the stack into the counter |
| target | input | 13 | Jump or call destination |
| fetch_addr | output | 11 | Physical program memory word address |
| pc_out | output | 13 | Full logical program counter |

## Verification
The collisions that matter most are an interrupt strobe arriving in the same cycle as a call, and a return arriving in the same cycle as a call. In each case both would want to write the counter and the stack. The bench asserts the strobe together with call, jump and increment, and later asserts return together with call. It judges the result by the next counter value and by what the following return pops. The interrupt case must land on 0004h and must leave exactly one new stack entry, holding the pre-interrupt counter. The return case must restore the saved address, and the call must leave no entry behind.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INC  = 3'd1,
    OP_JUMP = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_IRQ  = 3'd5
  } pc_op_e;
endpackage

// File: rtl/pcs_cmd_arb.sv
module pcs_cmd_arb
  import pcs_pkg::*;
(
  input  logic   irq_take,
  input  logic   cmd_ret,
  input  logic   cmd_call,
  input  logic   cmd_jump,
  input  logic   cmd_inc,
  output pc_op_e op
);
  // fixed precedence: interrupt, return, call, jump, increment
  always_comb begin
    if (irq_take)      op = OP_IRQ;
    else if (cmd_ret)  op = OP_RET;
    else if (cmd_call) op = OP_CALL;
    else if (cmd_jump) op = OP_JUMP;
    else if (cmd_inc)  op = OP_INC;
    else               op = OP_HOLD;
  end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 13,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] top_data,
  output logic [PTR_W-1:0] sp_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] sp_dec;

  function automatic logic [PTR_W-1:0] ring_up(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : PTR_W'(int'(p) + 1);
  endfunction

  function automatic logic [PTR_W-1:0] ring_down(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : PTR_W'(int'(p) - 1);
  endfunction

  assign sp_dec   = ring_down(sp_q);
  assign top_data = mem_q[sp_dec];
  assign sp_o     = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push) begin
      mem_q[sp_q] <= push_data;
      sp_q        <= ring_up(sp_q);
    end else if (pop) begin
      sp_q <= sp_dec;
    end
  end
endmodule

// File: rtl/pcs_pc_reg.sv
module pcs_pc_reg
  import pcs_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int RESET_VEC = 0,
  parameter int INT_VEC   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pc_op_e          op,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] pop_data,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] pc_seq
);
  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  logic [PC_W-1:0] pc_d;

  assign pc_seq = seq_next(pc_q);

  always_comb begin
    unique case (op)
      OP_IRQ:  pc_d = PC_W'(INT_VEC);
      OP_RET:  pc_d = pop_data;
      OP_CALL: pc_d = target;
      OP_JUMP: pc_d = target;
      OP_INC:  pc_d = pc_seq;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= PC_W'(RESET_VEC);
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcs_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int PHYS_W    = 11,
  parameter int DEPTH     = 8,
  parameter int RESET_VEC = 0,
  parameter int INT_VEC   = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_take,
  input  logic              cmd_inc,
  input  logic              cmd_jump,
  input  logic              cmd_call,
  input  logic              cmd_ret,
  input  logic [PC_W-1:0]   target,
  output logic [PHYS_W-1:0] fetch_addr,
  output logic [PC_W-1:0]   pc_out
);
  pc_op_e          op;
  logic            push_ev;
  logic            pop_ev;
  logic [PC_W-1:0] push_val;
  logic [PC_W-1:0] tos;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_seq;
  logic [PTR_W-1:0] sp;

  pcs_cmd_arb arb_i (
    .irq_take (irq_take),
    .cmd_ret  (cmd_ret),
    .cmd_call (cmd_call),
    .cmd_jump (cmd_jump),
    .cmd_inc  (cmd_inc),
    .op       (op)
  );

  assign push_ev  = (op == OP_CALL) || (op == OP_IRQ);
  assign pop_ev   = (op == OP_RET);
  assign push_val = (op == OP_IRQ) ? pc_q : pc_seq;

  pcs_ret_stack #(.DEPTH(DEPTH), .WIDTH(PC_W)) stk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_ev),
    .pop       (pop_ev),
    .push_data (push_val),
    .top_data  (tos),
    .sp_o      (sp)
  );

  pcs_pc_reg #(.PC_W(PC_W), .RESET_VEC(RESET_VEC), .INT_VEC(INT_VEC)) pcr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .target   (target),
    .pop_data (tos),
    .pc_q     (pc_q),
    .pc_seq   (pc_seq)
  );

  assign pc_out     = pc_q;
  assign fetch_addr = pc_q[PHYS_W-1:0];
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
  import pcs_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int RESET_VEC = 0,
  parameter int INT_VEC   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input pc_op_e          op,
  input logic            irq_take,
  input logic [PC_W-1:0] target,
  input logic [PC_W-1:0] pc_out,
  input logic [PC_W-1:0] tos
);
  AST_RESET_LOAD: assert property (@(posedge clk) !rst_n |=> (pc_out == PC_W'(RESET_VEC))); // R1
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_HOLD) |=> $stable(pc_out)); // R2
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_INC) |=> (pc_out == PC_W'($past(pc_out) + 1))); // R3
  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_JUMP) |=> (pc_out == $past(target))); // R5
  AST_CALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_CALL) |=> (pc_out == $past(target) && tos == PC_W'($past(pc_out) + 1))); // R6
  AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_RET) |=> (pc_out == $past(tos))); // R7
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) irq_take |=> (pc_out == PC_W'(INT_VEC) && tos == $past(pc_out))); // R8 R9
endmodule

bind pc_stack_unit pcs_checker #(.PC_W(PC_W), .RESET_VEC(RESET_VEC), .INT_VEC(INT_VEC)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .op       (op),
  .irq_take (irq_take),
  .target   (target),
  .pc_out   (pc_out),
  .tos      (tos)
);

// File: tb/pc_stack_unit_tb_top.sv
`timescale 1ns/1ps
module pc_stack_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_take = 1'b0, cmd_inc = 1'b0, cmd_jump = 1'b0, cmd_call = 1'b0, cmd_ret = 1'b0;
  logic [12:0] target = '0;
  logic [10:0] fetch_addr;
  logic [12:0] pc_out;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pc_stack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .cmd_inc(cmd_inc),
    .cmd_jump(cmd_jump), .cmd_call(cmd_call), .cmd_ret(cmd_ret),
    .target(target), .fetch_addr(fetch_addr), .pc_out(pc_out)
  );

  task automatic check(input string req, input logic [12:0] got, input logic [12:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one cycle of inputs, then release them just after the edge
  task automatic apply(input bit irq, input bit ret, input bit call, input bit jmp,
                       input bit inc, input logic [12:0] tgt);
    irq_take = irq; cmd_ret = ret; cmd_call = call; cmd_jump = jmp; cmd_inc = inc; target = tgt;
    @(posedge clk); #1;
    irq_take = 0; cmd_ret = 0; cmd_call = 0; cmd_jump = 0; cmd_inc = 0; target = '0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(posedge clk); #1;
    rst_n = 1;
  endtask

  task automatic t_reset();
    apply(0,0,0,1,0,13'h0155);
    do_reset();
    check("R1 pc", pc_out, 13'h0000);
    check("R1 fetch", {2'b0, fetch_addr}, 13'h0000);
    apply(0,1,0,0,0,'0);
    check("R1 empty pop", pc_out, 13'h0000);
  endtask

  task automatic t_hold();
    apply(0,0,0,1,0,13'h0321);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check("R2 hold", pc_out, 13'h0321);
    end
  endtask

  task automatic t_inc();
    apply(0,0,0,1,0,13'h1FFE);
    check("R5 jump", pc_out, 13'h1FFE);
    apply(0,0,0,0,1,'0);
    check("R3 inc", pc_out, 13'h1FFF);
    apply(0,0,0,0,1,'0);
    check("R3 wrap", pc_out, 13'h0000);
  endtask

  task automatic t_fetch();
    apply(0,0,0,1,0,13'h0ABC);
    check("R4 fold", {2'b0, fetch_addr}, 13'h02BC);
    apply(0,0,0,1,0,13'h07FF);
    check("R4 top", {2'b0, fetch_addr}, 13'h07FF);
    apply(0,0,0,0,1,'0);
    check("R4 past top", {2'b0, fetch_addr}, 13'h0000);
    check("R4 pc full", pc_out, 13'h0800);
  endtask

  task automatic t_call_ret();
    apply(0,0,0,1,0,13'h1F00);
    apply(0,0,1,0,0,13'h0123);
    check("R6 call target", pc_out, 13'h0123);
    apply(0,0,1,0,0,13'h0456);
    check("R6 nested call", pc_out, 13'h0456);
    apply(0,1,0,0,0,'0);
    check("R7 pop newest", pc_out, 13'h0124);
    apply(0,1,0,0,0,'0);
    check("R7 pop older", pc_out, 13'h1F01);
    apply(0,0,0,1,0,13'h1FFF);
    apply(0,0,1,0,0,13'h0010);
    apply(0,1,0,0,0,'0);
    check("R6 push wraps 13b", pc_out, 13'h0000);
  endtask

  task automatic t_irq();
    apply(0,0,0,1,0,13'h0200);
    apply(1,0,0,0,0,'0);
    check("R8 vector", pc_out, 13'h0004);
    apply(0,1,0,0,0,'0);
    check("R8 resume", pc_out, 13'h0200);
  endtask

  task automatic t_prio();
    apply(0,0,0,1,0,13'h0300);
    apply(1,0,1,1,1,13'h0077);
    check("R9 irq wins", pc_out, 13'h0004);
    apply(0,1,0,0,0,'0);
    check("R9 irq single push", pc_out, 13'h0300);
    apply(0,0,1,0,0,13'h0050);
    apply(0,1,1,1,0,13'h0099);
    check("R9 ret beats call", pc_out, 13'h0301);
    apply(0,0,1,1,1,13'h0066);
    check("R9 call beats jump", pc_out, 13'h0066);
    apply(0,1,0,0,0,'0);
    check("R9 call pushed", pc_out, 13'h0302);
    apply(0,0,0,1,1,13'h0040);
    check("R9 jump beats inc", pc_out, 13'h0040);
  endtask

  task automatic t_ring();
    logic [12:0] pushed [9];
    logic [12:0] pc_m;
    do_reset();
    apply(0,0,0,1,0,13'h0100);
    pc_m = 13'h0100;
    for (int k = 1; k <= 9; k++) begin
      pushed[k-1] = pc_m + 13'd1;
      apply(0,0,1,0,0,13'(16 * k));
      pc_m = 13'(16 * k);
    end
    for (int k = 8; k >= 1; k--) begin
      apply(0,1,0,0,0,'0);
      check("R10 lifo", pc_out, pushed[k]);
    end
    apply(0,1,0,0,0,'0);
    check("R10 ring overwrite", pc_out, pushed[8]);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 in reset", pc_out, 13'h0000);
    rst_n = 1;
    t_reset();
    t_hold();
    t_inc();
    t_fetch();
    t_call_ret();
    t_irq();
    t_prio();
    t_ring();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule